// File: doc/BRIEF.md
# Privileged System Instruction Unit

This block executes the four 32-bit privileged system instructions of a RISC-V hart: the environment call, the machine-level trap return, the supervisor-level trap return and the wait-for-interrupt hint. It owns the current privilege level, the machine status word and the two saved exception program counters (machine and supervisor). On every cycle with the valid strobe high it reports the program counter of the next instruction and, when the instruction must trap, a synchronous exception request with its cause code. A legal return commits its status-stack pop and its privilege change on the clock edge that retires it.

Trap entry itself (writing cause and saved PC, vectoring), interrupts and any real sleep are handled elsewhere. A small write port loads the status word and the two saved PCs in cycles with no instruction presented, so that the surrounding pipeline (or a bench) can set up the state the return instructions consume. The parameter `HAS_UMODE` says whether user mode exists. It selects what the machine return leaves behind in the saved-privilege field.

Top module: `psys_unit`

## Requirements
- R1: An instruction is recognised only if all 32 bits match its encoding: 0x00000073 (environment call), 0x30200073 (machine return), 0x10200073 (supervisor return), 0x10500073 (wait). Any other word presented with `valid_i` high raises no exception, changes no state and reports `pc_i + 4`. With `valid_i` low, `exc_valid_o` is 0.
- R2: The environment call always raises an exception with cause 8 + current privilege (8 from user, 9 from supervisor, 11 from machine), reports `pc_i + 4` and changes no state.
- R3: A machine return issued below machine privilege (level 3) raises cause 2, reports `pc_i + 4` and leaves privilege and status unchanged.
- R4: A legal machine return reports the machine saved PC (CSR address 0x341) as next PC, sets the privilege to status bits [12:11], and clears status bit 17 when that saved value is not 3 (bit 17 is kept when it is 3).
- R5: A legal machine return copies status bit 7 into bit 3, sets bit 7 to 1, and rewrites bits [12:11] to 0 when `HAS_UMODE` is 1, else to 3.
- R6: A supervisor return raises cause 2 with no state change and next PC `pc_i + 4` when privilege is 0, or when privilege is below 3 and status bit 22 is 1.
- R7: A legal supervisor return reports the supervisor saved PC (CSR address 0x141) as next PC, sets privilege to status bit 8, copies bit 5 into bit 1, sets bit 5 to 1 and clears bit 8.
- R8: The wait instruction raises no exception, reports `pc_i + 4` and changes no state.
- R9: Reset (synchronous, active high) sets privilege to 3 and the status word to 0.
- R10: The write port loads status (address 0x300), machine saved PC (0x341) or supervisor saved PC (0x141) on a clock edge with `csr_we_i` high and `valid_i` low. A write in a cycle with `valid_i` high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word is presented this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the presented instruction |
| csr_we_i | input | 1 | State-load write enable |
| csr_addr_i | input | 12 | State-load CSR address |
| csr_wdata_i | input | 32 | State-load data |
| next_pc_o | output | 32 | Next program counter for the presented instruction |
| exc_valid_o | output | 1 | Synchronous exception request |
| exc_cause_o | output | 4 | Exception cause code |
| priv_o | output | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| status_o | output | 32 | Current status word |

## Verification
Each instruction is presented at every privilege level it can reach, so that legal and faulting paths of both returns are both taken. The environment call from three levels separates the cause arithmetic from a fixed code. Machine returns with the saved field at 3 and at 1 tell the conditional clearing of bit 17 apart from an unconditional one, and supervisor returns with bit 22 clear and set, in supervisor and user mode, tell the two fault conditions apart. Near-miss words that differ in a single register field from a real encoding, and a state-load write made alongside a valid instruction, show that the decoder demands an exact match and that the write port stands aside.

// File: rtl/psys_pkg.sv
package psys_pkg;

    localparam int XLEN    = 32;
    localparam int CAUSE_W = 4;
    localparam int CSR_AW  = 12;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ECALL,
        OP_MRET,
        OP_SRET,
        OP_WFI
    } sysop_e;

    localparam logic [31:0] ENC_ECALL = 32'h0000_0073;
    localparam logic [31:0] ENC_MRET  = 32'h3020_0073;
    localparam logic [31:0] ENC_SRET  = 32'h1020_0073;
    localparam logic [31:0] ENC_WFI   = 32'h1050_0073;

    localparam logic [CSR_AW-1:0] ADDR_STATUS = 12'h300;
    localparam logic [CSR_AW-1:0] ADDR_MEPC   = 12'h341;
    localparam logic [CSR_AW-1:0] ADDR_SEPC   = 12'h141;

    // status word bit positions
    localparam int ST_SIE    = 1;
    localparam int ST_MIE    = 3;
    localparam int ST_SPIE   = 5;
    localparam int ST_MPIE   = 7;
    localparam int ST_SPP    = 8;
    localparam int ST_MPP_LO = 11;
    localparam int ST_MPP_HI = 12;
    localparam int ST_MPRV   = 17;
    localparam int ST_TSR    = 22;

    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL    = 4'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_ECALL_BASE = 4'd8;

    typedef struct packed {
        logic [XLEN-1:0]    next_pc;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
        logic               commit;
        priv_e              priv;
        logic [XLEN-1:0]    status;
    } retire_t;

    function automatic sysop_e match_word(input logic [31:0] w);
        sysop_e op;
        case (w)
            ENC_ECALL: op = OP_ECALL;
            ENC_MRET:  op = OP_MRET;
            ENC_SRET:  op = OP_SRET;
            ENC_WFI:   op = OP_WFI;
            default:   op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/psys_decode.sv
module psys_decode
    import psys_pkg::*;
(
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    output sysop_e      op_o
);
    always_comb begin
        op_o = valid_i ? match_word(instr_i) : OP_NONE;
    end
endmodule

// File: rtl/psys_exec.sv
module psys_exec
    import psys_pkg::*;
#(
    parameter bit HAS_UMODE = 1'b1
) (
    input  sysop_e          op_i,
    input  logic [XLEN-1:0] pc_i,
    input  priv_e           priv_i,
    input  logic [XLEN-1:0] status_i,
    input  logic [XLEN-1:0] mepc_i,
    input  logic [XLEN-1:0] sepc_i,
    output retire_t         res_o
);
    localparam logic [1:0] MPP_AFTER = HAS_UMODE ? 2'd0 : 2'd3;
    localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(4);

    logic [1:0]      saved_mpp;
    logic            mret_ok;
    logic            sret_ok;
    logic [XLEN-1:0] st_m;
    logic [XLEN-1:0] st_s;

    assign saved_mpp = status_i[ST_MPP_HI:ST_MPP_LO];
    assign mret_ok   = (priv_i == PRIV_M);
    assign sret_ok   = (priv_i != PRIV_U) &&
                       ((priv_i == PRIV_M) || !status_i[ST_TSR]);

    // status after a machine-level stack pop
    always_comb begin
        st_m = status_i;
        if (saved_mpp != 2'd3) st_m[ST_MPRV] = 1'b0;
        st_m[ST_MIE]  = status_i[ST_MPIE];
        st_m[ST_MPIE] = 1'b1;
        st_m[ST_MPP_HI:ST_MPP_LO] = MPP_AFTER;
    end

    // status after a supervisor-level stack pop
    always_comb begin
        st_s = status_i;
        st_s[ST_SIE]  = status_i[ST_SPIE];
        st_s[ST_SPIE] = 1'b1;
        st_s[ST_SPP]  = 1'b0;
    end

    always_comb begin
        res_o.next_pc = pc_i + INSTR_BYTES;
        res_o.exc     = 1'b0;
        res_o.cause   = '0;
        res_o.commit  = 1'b0;
        res_o.priv    = priv_i;
        res_o.status  = status_i;
        case (op_i)
            OP_ECALL: begin
                res_o.exc   = 1'b1;
                res_o.cause = CAUSE_ECALL_BASE + CAUSE_W'(priv_i);
            end
            OP_MRET: begin
                if (!mret_ok) begin
                    res_o.exc   = 1'b1;
                    res_o.cause = CAUSE_ILLEGAL;
                end else begin
                    res_o.next_pc = mepc_i;
                    res_o.commit  = 1'b1;
                    res_o.priv    = priv_e'(saved_mpp);
                    res_o.status  = st_m;
                end
            end
            OP_SRET: begin
                if (!sret_ok) begin
                    res_o.exc   = 1'b1;
                    res_o.cause = CAUSE_ILLEGAL;
                end else begin
                    res_o.next_pc = sepc_i;
                    res_o.commit  = 1'b1;
                    res_o.priv    = priv_e'({1'b0, status_i[ST_SPP]});
                    res_o.status  = st_s;
                end
            end
            default: ; // wait hint and unmatched words fall through
        endcase
    end
endmodule

// File: rtl/psys_state.sv
module psys_state
    import psys_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  retire_t           res_i,
    input  logic              csr_we_i,
    input  logic [CSR_AW-1:0] csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output priv_e             priv_o,
    output logic [XLEN-1:0]   status_o,
    output logic [XLEN-1:0]   mepc_o,
    output logic [XLEN-1:0]   sepc_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            priv_o   <= PRIV_M;
            status_o <= '0;
            mepc_o   <= '0;
            sepc_o   <= '0;
        end else if (valid_i) begin
            if (res_i.commit) begin
                priv_o   <= res_i.priv;
                status_o <= res_i.status;
            end
        end else if (csr_we_i) begin
            case (csr_addr_i)
                ADDR_STATUS: status_o <= csr_wdata_i;
                ADDR_MEPC:   mepc_o   <= csr_wdata_i;
                ADDR_SEPC:   sepc_o   <= csr_wdata_i;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/psys_unit.sv
module psys_unit
    import psys_pkg::*;
#(
    parameter bit HAS_UMODE = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [31:0]         instr_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic                csr_we_i,
    input  logic [CSR_AW-1:0]   csr_addr_i,
    input  logic [XLEN-1:0]     csr_wdata_i,
    output logic [XLEN-1:0]     next_pc_o,
    output logic                exc_valid_o,
    output logic [CAUSE_W-1:0]  exc_cause_o,
    output logic [1:0]          priv_o,
    output logic [XLEN-1:0]     status_o
);
    sysop_e          op;
    retire_t         res;
    priv_e           priv_q;
    logic [XLEN-1:0] status_q;
    logic [XLEN-1:0] mepc_q;
    logic [XLEN-1:0] sepc_q;

    psys_decode u_decode (
        .valid_i (valid_i),
        .instr_i (instr_i),
        .op_o    (op)
    );

    psys_exec #(.HAS_UMODE(HAS_UMODE)) u_exec (
        .op_i     (op),
        .pc_i     (pc_i),
        .priv_i   (priv_q),
        .status_i (status_q),
        .mepc_i   (mepc_q),
        .sepc_i   (sepc_q),
        .res_o    (res)
    );

    psys_state u_state (
        .clk         (clk),
        .rst         (rst),
        .valid_i     (valid_i),
        .res_i       (res),
        .csr_we_i    (csr_we_i),
        .csr_addr_i  (csr_addr_i),
        .csr_wdata_i (csr_wdata_i),
        .priv_o      (priv_q),
        .status_o    (status_q),
        .mepc_o      (mepc_q),
        .sepc_o      (sepc_q)
    );

    assign next_pc_o   = res.next_pc;
    assign exc_valid_o = res.exc;
    assign exc_cause_o = res.cause;
    assign priv_o      = priv_q;
    assign status_o    = status_q;
endmodule

// File: rtl/psys_unit_chk.sv
module psys_unit_chk
    import psys_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               valid_i,
    input logic [31:0]        instr_i,
    input logic [XLEN-1:0]    pc_i,
    input logic [XLEN-1:0]    next_pc_o,
    input logic               exc_valid_o,
    input logic [CAUSE_W-1:0] exc_cause_o,
    input logic [1:0]         priv_o,
    input logic [XLEN-1:0]    status_o
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> !exc_valid_o);

    assert_ecall_cause_R2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i == ENC_ECALL) |->
            (exc_valid_o && exc_cause_o == CAUSE_W'(8 + int'(priv_o))));

    assert_fault_holds_state_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && exc_valid_o) |=> ($stable(priv_o) && $stable(status_o)));

    assert_mret_priv_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i == ENC_MRET && priv_o == 2'd3) |=>
            (priv_o == $past(status_o[ST_MPP_HI:ST_MPP_LO])));

    assert_mret_stack_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i == ENC_MRET && priv_o == 2'd3) |=>
            (status_o[ST_MIE] == $past(status_o[ST_MPIE]) && status_o[ST_MPIE]));

    assert_sret_fault_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i == ENC_SRET &&
         (priv_o == 2'd0 || (priv_o != 2'd3 && status_o[ST_TSR]))) |->
            (exc_valid_o && exc_cause_o == CAUSE_ILLEGAL));

    assert_wfi_fallthrough_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i == ENC_WFI) |->
            (!exc_valid_o && next_pc_o == pc_i + 32'd4));

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (priv_o == 2'd3 && status_o == '0));
endmodule

bind psys_unit psys_unit_chk u_psys_unit_chk (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (valid_i),
    .instr_i     (instr_i),
    .pc_i        (pc_i),
    .next_pc_o   (next_pc_o),
    .exc_valid_o (exc_valid_o),
    .exc_cause_o (exc_cause_o),
    .priv_o      (priv_o),
    .status_o    (status_o)
);

// File: tb/psys_unit_bench.sv
module psys_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] pc_i = '0;
    logic        csr_we_i = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] next_pc_o;
    logic        exc_valid_o;
    logic [3:0]  exc_cause_o;
    logic [1:0]  priv_o;
    logic [31:0] status_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psys_unit u_psys_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
        .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i),
        .next_pc_o(next_pc_o), .exc_valid_o(exc_valid_o), .exc_cause_o(exc_cause_o),
        .priv_o(priv_o), .status_o(status_o)
    );

    typedef struct {
        logic [31:0] npc;
        logic        exc;
        logic [3:0]  cause;
        logic [1:0]  priv;
        logic [31:0] status;
        string       tag;
    } expect_t;

    expect_t sb[$];
    expect_t pend;
    bit      pend_on = 1'b0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: compares retire outputs, then the committed state one cycle later
    always @(negedge clk) begin
        if (pend_on) begin
            check(pend.tag, "priv",   {30'd0, priv_o}, {30'd0, pend.priv});
            check(pend.tag, "status", status_o, pend.status);
            pend_on = 1'b0;
        end
        if (valid_i && !rst) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard empty actual=result expected=none");
            end else begin
                pend = sb.pop_front();
                check(pend.tag, "next_pc", next_pc_o, pend.npc);
                check(pend.tag, "exc",     {31'd0, exc_valid_o}, {31'd0, pend.exc});
                if (pend.exc)
                    check(pend.tag, "cause", {28'd0, exc_cause_o}, {28'd0, pend.cause});
                pend_on = 1'b1;
            end
        end
    end

    task automatic load(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
        @(posedge clk); #1;
        csr_we_i = 1'b0;
    endtask

    task automatic issue(input logic [31:0] w, input logic [31:0] pc,
                         input logic [31:0] npc, input logic exc, input logic [3:0] cause,
                         input logic [1:0] priv, input logic [31:0] status,
                         input string tag, input logic side_write = 1'b0);
        expect_t e;
        @(posedge clk); #1;
        e.npc = npc; e.exc = exc; e.cause = cause;
        e.priv = priv; e.status = status; e.tag = tag;
        sb.push_back(e);
        valid_i = 1'b1; instr_i = w; pc_i = pc;
        if (side_write) begin
            csr_we_i = 1'b1; csr_addr_i = 12'h300; csr_wdata_i = 32'hFFFF_FFFF;
        end
        @(posedge clk); #1;
        valid_i = 1'b0; csr_we_i = 1'b0;
    endtask

    localparam logic [31:0] W_ECALL = 32'h0000_0073;
    localparam logic [31:0] W_MRET  = 32'h3020_0073;
    localparam logic [31:0] W_SRET  = 32'h1020_0073;
    localparam logic [31:0] W_WFI   = 32'h1050_0073;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R9", "reset priv",   {30'd0, priv_o}, 32'd3);
        check("R9", "reset status", status_o, 32'd0);
        check("R1", "idle exc",     {31'd0, exc_valid_o}, 32'd0);

        issue(W_ECALL, 32'h100, 32'h104, 1, 4'd11, 2'd3, 32'h0, "R2 ecall from M");

        load(12'h300, 32'h0002_1800);
        load(12'h341, 32'h0000_0200);
        issue(W_MRET, 32'h108, 32'h200, 0, 4'd0, 2'd3, 32'h0002_0080, "R4 R5 mret to M keeps bit17");

        load(12'h300, 32'h0002_0880);
        load(12'h341, 32'h8000_0100);
        issue(W_MRET, 32'h20C, 32'h8000_0100, 0, 4'd0, 2'd1, 32'h0000_0088, "R4 R5 mret to S clears bit17");

        issue(W_ECALL, 32'h1000, 32'h1004, 1, 4'd9, 2'd1, 32'h88, "R2 ecall from S");
        issue(W_MRET,  32'h1004, 32'h1008, 1, 4'd2, 2'd1, 32'h88, "R3 mret from S");

        load(12'h300, 32'h0000_01A8);
        load(12'h141, 32'h4000_0200);
        issue(W_SRET, 32'h1008, 32'h4000_0200, 0, 4'd0, 2'd1, 32'h0000_00AA, "R7 sret to S");

        load(12'h300, 32'h0040_00AA);
        issue(W_SRET, 32'h2000, 32'h2004, 1, 4'd2, 2'd1, 32'h0040_00AA, "R6 sret in S with bit22");

        load(12'h300, 32'h0000_0020);
        issue(W_SRET, 32'h2004, 32'h4000_0200, 0, 4'd0, 2'd0, 32'h0000_0022, "R7 sret to U");

        issue(W_ECALL, 32'h3000, 32'h3004, 1, 4'd8, 2'd0, 32'h22, "R2 ecall from U");
        issue(W_SRET,  32'h3004, 32'h3008, 1, 4'd2, 2'd0, 32'h22, "R6 sret from U");
        issue(W_MRET,  32'h3008, 32'h300C, 1, 4'd2, 2'd0, 32'h22, "R3 mret from U");
        issue(W_WFI,   32'h300C, 32'h3010, 0, 4'd0, 2'd0, 32'h22, "R8 wait hint");
        issue(32'h0010_0073, 32'h3010, 32'h3014, 0, 4'd0, 2'd0, 32'h22, "R1 near-miss word");
        issue(32'h3020_00F3, 32'h3014, 32'h3018, 0, 4'd0, 2'd0, 32'h22, "R1 return with rd set");
        issue(W_WFI, 32'h3018, 32'h301C, 0, 4'd0, 2'd0, 32'h22, "R10 write beside valid ignored", 1'b1);

        load(12'h300, 32'h0000_0123);
        @(negedge clk);
        check("R10", "status load", status_o, 32'h0000_0123);

        repeat (2) @(posedge clk);
        check("R1", "scoreboard drained", sb.size(), 32'd0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule